// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address (a segment number and an offset) into a flat physical address. It holds a small table of segments. Each entry has a starting physical address (the base), a length (the limit) and a valid flag. Supervisor code fills the table through a load port that accepts a write only when a privilege qualifier is high. Without that qualifier the write is discarded.

For each request the unit looks up the selected entry and compares the offset with the entry's length. An offset inside the segment produces base plus offset. Otherwise the unit raises a trap with a fault code that tells the supervisor why. A segment number that names no valid entry also traps, with its own code, and this takes precedence over the length check. The response is registered and appears one clock after the request.

Top module: `seg_xlat_top`

## Requirements
- R1: After reset every table entry is invalid and `rsp_valid` is low. A request made before any load returns fault code 2'b10.
- R2: A load takes effect only when `ld_en` and `ld_priv` are both high at a rising edge. Requests sampled at later edges see the new entry. A request sampled at the same edge as the load sees the old contents.
- R3: A load attempted with `ld_en` high and `ld_priv` low leaves the table unchanged.
- R4: When the entry is valid and the offset is below its limit, `rsp_paddr` equals base plus the zero-extended offset, modulo 2^PHYS_W. In this case `rsp_fault` is 0 and `rsp_code` is 2'b00.
- R5: When the entry is valid and the offset is greater than or equal to its limit, `rsp_fault` is 1, `rsp_code` is 2'b01 and `rsp_paddr` is 0. A limit of 0 makes every offset trap.
- R6: A segment number greater than or equal to SEG_COUNT (5 by default, valid numbers 0 to 4), or one whose entry is invalid, gives `rsp_fault` 1, `rsp_code` 2'b10 and `rsp_paddr` 0, whatever the offset.
- R7: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` was sampled high.
- R8: A privileged load with `ld_valid` low marks the entry invalid, so later requests to that segment return code 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Table load strobe |
| ld_priv | input | 1 | Privilege qualifier for the load |
| ld_seg | input | SEG_W | Entry index to load |
| ld_valid | input | 1 | Valid flag written into the entry |
| ld_base | input | PHYS_W | Segment base written into the entry |
| ld_limit | input | OFF_W | Segment length written into the entry |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | SEG_W | Segment number of the logical address |
| req_off | input | OFF_W | Offset of the logical address |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | PHYS_W | Physical address, 0 on a trap |
| rsp_fault | output | 1 | Trap raised |
| rsp_code | output | 2 | 00 none, 01 beyond limit, 10 no such segment |

## Verification
The embedded properties check the following on every clock:
- the one-cycle request-to-response timing;
- the zero address carried on each trap;
- the no-segment code for indices past the table;
- that the table's valid flags do not move without a granted load.

The translation arithmetic, the exact limit boundary, the zero-length segment and the same-edge load and request ordering depend on table contents. Only the bench's scenarios show these, by comparing against its own model of the table.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

   typedef enum logic [1:0] {
      XF_NONE  = 2'b00,
      XF_LIMIT = 2'b01,
      XF_NOSEG = 2'b10
   } xfault_e;

endpackage

// File: rtl/seg_xlat_table.sv
module seg_xlat_table #(
   parameter int SEG_COUNT = 5,
   parameter int SEG_W     = 3,
   parameter int OFF_W     = 12,
   parameter int PHYS_W    = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEG_W-1:0]  wr_seg,
   input  logic              wr_valid,
   input  logic [PHYS_W-1:0] wr_base,
   input  logic [OFF_W-1:0]  wr_limit,
   input  logic [SEG_W-1:0]  rd_seg,
   output logic              rd_hit,
   output logic [PHYS_W-1:0] rd_base,
   output logic [OFF_W-1:0]  rd_limit
);

   logic [SEG_COUNT-1:0] valid_q;
   logic [PHYS_W-1:0]    base_q  [SEG_COUNT];
   logic [OFF_W-1:0]     limit_q [SEG_COUNT];

   for (genvar g = 0; g < SEG_COUNT; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            base_q[g]  <= '0;
            limit_q[g] <= '0;
         end else if (wr_en && wr_seg == SEG_W'(g)) begin
            valid_q[g] <= wr_valid;
            base_q[g]  <= wr_base;
            limit_q[g] <= wr_limit;
         end
      end
   end

   // Indices past the table match no entry and so report no hit.
   always_comb begin
      rd_hit   = 1'b0;
      rd_base  = '0;
      rd_limit = '0;
      for (int i = 0; i < SEG_COUNT; i++) begin
         if (rd_seg == SEG_W'(i)) begin
            rd_hit   = valid_q[i];
            rd_base  = base_q[i];
            rd_limit = limit_q[i];
         end
      end
   end

   // R3
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(valid_q));

endmodule

// File: rtl/seg_xlat_check.sv
module seg_xlat_check
   import seg_xlat_pkg::*;
#(
   parameter int OFF_W  = 12,
   parameter int PHYS_W = 20
) (
   input  logic              hit,
   input  logic [PHYS_W-1:0] base,
   input  logic [OFF_W-1:0]  limit,
   input  logic [OFF_W-1:0]  off,
   output xfault_e           code,
   output logic [PHYS_W-1:0] paddr
);

   logic in_bounds;
   assign in_bounds = off < limit;

   always_comb begin
      code  = XF_NONE;
      paddr = '0;
      if (!hit) begin
         code = XF_NOSEG;
      end else if (!in_bounds) begin
         code = XF_LIMIT;
      end else begin
         paddr = base + PHYS_W'(off);
      end
   end

endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
   import seg_xlat_pkg::*;
#(
   parameter int SEG_COUNT = 5,
   parameter int SEG_W     = 3,
   parameter int OFF_W     = 12,
   parameter int PHYS_W    = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              ld_priv,
   input  logic [SEG_W-1:0]  ld_seg,
   input  logic              ld_valid,
   input  logic [PHYS_W-1:0] ld_base,
   input  logic [OFF_W-1:0]  ld_limit,
   input  logic              req_valid,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   output logic              rsp_valid,
   output logic [PHYS_W-1:0] rsp_paddr,
   output logic              rsp_fault,
   output logic [1:0]        rsp_code
);

   localparam int SEG_SPAN = 1 << SEG_W;

   if (SEG_COUNT < 1 || SEG_COUNT > SEG_SPAN) begin : g_bad_count
      $error("SEG_COUNT must be between 1 and 2**SEG_W");
   end
   if (PHYS_W < OFF_W) begin : g_bad_width
      $error("PHYS_W must not be narrower than OFF_W");
   end

   logic              tab_wr;
   logic              tab_hit;
   logic [PHYS_W-1:0] tab_base;
   logic [OFF_W-1:0]  tab_limit;
   xfault_e           chk_code;
   logic [PHYS_W-1:0] chk_paddr;

   assign tab_wr = ld_en & ld_priv;

   seg_xlat_table #(
      .SEG_COUNT(SEG_COUNT), .SEG_W(SEG_W), .OFF_W(OFF_W), .PHYS_W(PHYS_W)
   ) u_tab (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tab_wr), .wr_seg(ld_seg), .wr_valid(ld_valid),
      .wr_base(ld_base), .wr_limit(ld_limit),
      .rd_seg(req_seg), .rd_hit(tab_hit), .rd_base(tab_base), .rd_limit(tab_limit)
   );

   seg_xlat_check #(.OFF_W(OFF_W), .PHYS_W(PHYS_W)) u_chk (
      .hit(tab_hit), .base(tab_base), .limit(tab_limit), .off(req_off),
      .code(chk_code), .paddr(chk_paddr)
   );

   xfault_e code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         code_q    <= XF_NONE;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            code_q    <= chk_code;
            rsp_paddr <= chk_paddr;
         end
      end
   end

   assign rsp_code  = code_q;
   assign rsp_fault = (code_q != XF_NONE);

   // R7
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R7
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R6
   seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && int'(req_seg) >= SEG_COUNT) |=> (rsp_code == XF_NOSEG));

   // R5
   trap_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

endmodule

// File: tb/seg_xlat_top_test.sv
module seg_xlat_top_test;

   localparam int CLK_PERIOD = 10;
   localparam int SEG_COUNT  = 5;
   localparam int SEG_W      = 3;
   localparam int OFF_W      = 12;
   localparam int PHYS_W     = 20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ld_en = 1'b0, ld_priv = 1'b0, ld_valid = 1'b0;
   logic [SEG_W-1:0]  ld_seg = '0;
   logic [PHYS_W-1:0] ld_base = '0;
   logic [OFF_W-1:0]  ld_limit = '0;
   logic              req_valid = 1'b0;
   logic [SEG_W-1:0]  req_seg = '0;
   logic [OFF_W-1:0]  req_off = '0;
   logic              rsp_valid;
   logic [PHYS_W-1:0] rsp_paddr;
   logic              rsp_fault;
   logic [1:0]        rsp_code;

   seg_xlat_top #(
      .SEG_COUNT(SEG_COUNT), .SEG_W(SEG_W), .OFF_W(OFF_W), .PHYS_W(PHYS_W)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_en), .ld_priv(ld_priv), .ld_seg(ld_seg), .ld_valid(ld_valid),
      .ld_base(ld_base), .ld_limit(ld_limit),
      .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_code(rsp_code)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit mon_on = 1'b0;

   logic              m_valid [8];
   logic [PHYS_W-1:0] m_base  [8];
   logic [OFF_W-1:0]  m_limit [8];

   logic [PHYS_W-1:0] q_addr [$];
   logic [1:0]        q_code [$];
   string             q_tag  [$];

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // One cycle of stimulus: the expectation uses the table before the load.
   task automatic step(input bit le, input bit lp, input int ls, input bit lv,
                       input int lb, input int ll,
                       input bit rv, input int rs, input int ro, input string tag);
      @(negedge clk);
      ld_en = le; ld_priv = lp; ld_seg = SEG_W'(ls); ld_valid = lv;
      ld_base = PHYS_W'(lb); ld_limit = OFF_W'(ll);
      req_valid = rv; req_seg = SEG_W'(rs); req_off = OFF_W'(ro);
      if (rv) begin
         if (rs >= SEG_COUNT || !m_valid[rs]) begin
            q_code.push_back(2'b10); q_addr.push_back('0);
         end else if (ro >= int'(m_limit[rs])) begin
            q_code.push_back(2'b01); q_addr.push_back('0);
         end else begin
            q_code.push_back(2'b00);
            q_addr.push_back(m_base[rs] + PHYS_W'(ro));
         end
         q_tag.push_back(tag);
      end
      if (le && lp) begin
         m_valid[ls] = lv; m_base[ls] = PHYS_W'(lb); m_limit[ls] = OFF_W'(ll);
      end
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   // Monitor: compares one response per request after each edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (mon_on) begin
            if (q_tag.size() != 0) begin
               string t;
               logic [1:0] ec;
               logic [PHYS_W-1:0] ea;
               t = q_tag.pop_front(); ec = q_code.pop_front(); ea = q_addr.pop_front();
               check(rsp_valid == 1'b1, "R7", "rsp_valid", rsp_valid, 1);
               check(rsp_code == ec, t, "rsp_code", rsp_code, ec);
               check(rsp_fault == (ec != 2'b00), t, "rsp_fault", rsp_fault, ec != 2'b00);
               check(rsp_paddr == ea, t, "rsp_paddr", rsp_paddr, ea);
            end else begin
               check(rsp_valid == 1'b0, "R7", "idle rsp_valid", rsp_valid, 0);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_valid[i] = 1'b0; m_base[i] = '0; m_limit[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
      mon_on = 1'b1;
      // R1: empty table
      step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R1");
      step(0, 0, 0, 0, 0, 0, 1, 4, 7, "R1");
      // R3: unprivileged load discarded
      step(1, 0, 2, 1, 4300, 400, 0, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 1, 2, 53, "R3");
      // R2: privileged loads
      step(1, 1, 0, 1, 1400, 1000, 0, 0, 0, "");
      step(1, 1, 2, 1, 4300, 400, 1, 2, 53, "R2");
      step(1, 1, 3, 1, 3200, 1100, 1, 2, 53, "R4");
      step(0, 0, 0, 0, 0, 0, 1, 3, 852, "R4");
      // R2: same-edge load and request sees old contents
      step(1, 1, 4, 1, 4700, 1000, 1, 4, 5, "R2");
      step(0, 0, 0, 0, 0, 0, 1, 4, 5, "R2");
      idle();
      // R5: limit boundaries
      step(0, 0, 0, 0, 0, 0, 1, 0, 1222, "R5");
      step(0, 0, 0, 0, 0, 0, 1, 0, 999, "R4");
      step(0, 0, 0, 0, 0, 0, 1, 0, 1000, "R5");
      step(0, 0, 0, 0, 0, 0, 1, 2, 399, "R4");
      step(0, 0, 0, 0, 0, 0, 1, 2, 400, "R5");
      // R6: out-of-range segment numbers
      step(0, 0, 0, 0, 0, 0, 1, 5, 0, "R6");
      step(0, 0, 0, 0, 0, 0, 1, 7, 4000, "R6");
      // R8: invalidate then query, including large offset (priority)
      step(1, 1, 3, 0, 3200, 1100, 0, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 1, 3, 10, "R8");
      step(0, 0, 0, 0, 0, 0, 1, 3, 4095, "R6");
      // R5: zero-length segment
      step(1, 1, 1, 1, 500, 0, 0, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 1, 1, 0, "R5");
      // R4: wraparound at top of physical space
      step(1, 1, 4, 1, (1 << PHYS_W) - 4, 100, 0, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 1, 4, 10, "R4");
      step(0, 0, 0, 0, 0, 0, 1, 4, 3, "R4");
      // R3: unprivileged overwrite of a live entry
      step(1, 0, 0, 0, 9, 9, 0, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 1, 0, 5, "R3");
      idle();
      idle();
      idle();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule